// File: doc/BRIEF.md
# Blit Alignment Parameter Calculator

This unit turns pixel coordinates into the setup values that a word-oriented block-copy engine needs. The caller gives the leftmost pixel column of the source and of the destination and the width of the block in pixels. The unit returns the partial-word masks for the two line edges, the bit skew between source and destination, the extra-first-read and skipped-last-read flags, and the number of destination words per line. It also returns the word spans of source and destination and the end-of-line address increments built from them, given a word step and a line pitch for each side.

The calculation is sequential. A start pulse captures the inputs. Two clock edges later every output is updated together and a one-cycle done pulse is raised. Only left-to-right copies with no overlap are covered. Multiplying row and plane bases is left to the caller. The read flags come from a three-bit alignment class, so software does not pick them.

Top module: `blit_align_calc`

## Requirements
- R1: While and after reset, busy and done are low and every result output is zero.
- R2: A start seen in the idle state raises busy on the next edge. The results and a single-cycle done appear on the edge after that. busy falls at the edge where done rises.
- R3: A start that arrives while busy is high is ignored. It gives no extra done pulse, and inputs that change during that cycle do not reach the results.
- R4: For each side, the maximum column is min + width - 1 (16-bit wrap). The word span is (max >> 4) - (min >> 4). words_per_line equals the destination span plus one.
- R5: mask_right is the complement of 16'h7FFF shifted right by (destination max mod 16). mask_mid is always 16'hFFFF. For a destination wider than one word, mask_left is 16'hFFFF shifted right by (destination min mod 16).
- R6: When the destination span is zero, mask_left is the AND of the left and right edge masks.
- R7: skew is (destination min mod 16) - (source min mod 16), truncated to 4 bits.
- R8: An alignment class is formed from three bits. Bit 0 is source min mod 16 > destination min mod 16. Bit 1 is source span == destination span. Bit 2 is destination span == 0. The flags {xfirst, nolast} are 00 for classes 2, 4, 6 and 7, 01 for class 0, 10 for classes 1 and 5, and 11 for class 3.
- R9: src_line_inc = src_pitch - src_step * src_span and dst_line_inc = dst_pitch - dst_step * dst_span, both modulo 2^16.
- R10: The results keep their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calculation (idle only) |
| src_xmin | input | 16 | Leftmost source pixel column |
| dst_xmin | input | 16 | Leftmost destination pixel column |
| width | input | 16 | Block width in pixels (at least 1) |
| src_step | input | 16 | Source byte step between words |
| dst_step | input | 16 | Destination byte step between words |
| src_pitch | input | 16 | Source byte pitch between lines |
| dst_pitch | input | 16 | Destination byte pitch between lines |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse: results updated |
| mask_left | output | 16 | Mask for the first word of a line |
| mask_mid | output | 16 | Mask for the inner words |
| mask_right | output | 16 | Mask for the last word of a line |
| skew | output | 4 | Source-to-destination bit skew |
| xfirst | output | 1 | Perform an extra source read at line start |
| nolast | output | 1 | Skip the final source read of a line |
| words_per_line | output | 16 | Destination words per line |
| src_span | output | 16 | Source word span minus nothing: last word index minus first |
| dst_span | output | 16 | Destination word span |
| src_line_inc | output | 16 | Source end-of-line increment |
| dst_line_inc | output | 16 | Destination end-of-line increment |

## Verification
Two things can happen in the same cycle: a new start request and the final stage that writes the results and raises done. The bench holds start high into the busy cycle and changes every input at that moment. It then checks three things: only one done pulse appears, the results match the first input set, and a start issued in the cycle right after done is accepted normally. A single-word destination is driven into each alignment class, so the merged mask and the flag table are checked together for the same request.

// File: rtl/blit_calc_pkg.sv
package blit_calc_pkg;

  typedef logic [2:0] align_class_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPAN  = 2'd1
  } calc_state_t;

  // returns {xfirst, nolast}
  function automatic logic [1:0] read_flags(input align_class_t cls);
    logic [1:0] f;
    case (cls)
      3'd0:    f = 2'b01;
      3'd1:    f = 2'b10;
      3'd3:    f = 2'b11;
      3'd5:    f = 2'b10;
      default: f = 2'b00;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/blit_edge_span.sv
module blit_edge_span #(
  parameter int COORD_W = 16,
  parameter int WORD_W  = 16,
  localparam int OFS_W  = $clog2(WORD_W)
) (
  input  logic [COORD_W-1:0] xmin,
  input  logic [COORD_W-1:0] width,
  output logic [OFS_W-1:0]   off_lo,
  output logic [OFS_W-1:0]   off_hi,
  output logic [COORD_W-1:0] span
);
  logic [COORD_W-1:0] xmax;
  logic [COORD_W-1:0] w_lo, w_hi;

  always_comb begin
    xmax   = xmin + width - COORD_W'(1);
    off_lo = xmin[OFS_W-1:0];
    off_hi = xmax[OFS_W-1:0];
    w_lo   = xmin >> OFS_W;
    w_hi   = xmax >> OFS_W;
    span   = w_hi - w_lo;
  end
endmodule

// File: rtl/blit_mask_gen.sv
module blit_mask_gen #(
  parameter int WORD_W = 16,
  localparam int OFS_W = $clog2(WORD_W)
) (
  input  logic [OFS_W-1:0]  off_lo,
  input  logic [OFS_W-1:0]  off_hi,
  input  logic              single,
  output logic [WORD_W-1:0] m_left,
  output logic [WORD_W-1:0] m_right
);
  localparam logic [WORD_W-1:0] ALL1  = '1;
  localparam logic [WORD_W-1:0] LOW1S = ALL1 >> 1;

  logic [WORD_W-1:0] edge_l, edge_r;

  always_comb begin
    edge_l  = ALL1 >> off_lo;
    edge_r  = ~(LOW1S >> off_hi);
    m_right = edge_r;
    m_left  = single ? (edge_l & edge_r) : edge_l;
  end
endmodule

// File: rtl/blit_line_inc.sv
module blit_line_inc #(
  parameter int COORD_W = 16,
  parameter int INC_W   = 16
) (
  input  logic [INC_W-1:0]   step,
  input  logic [INC_W-1:0]   pitch,
  input  logic [COORD_W-1:0] span,
  output logic [INC_W-1:0]   inc
);
  logic [INC_W-1:0] span_x, prod;

  always_comb begin
    span_x = INC_W'(span);
    prod   = step * span_x;
    inc    = pitch - prod;
  end
endmodule

// File: rtl/blit_align_calc.sv
module blit_align_calc
  import blit_calc_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int WORD_W  = 16,
  parameter int INC_W   = 16,
  localparam int OFS_W  = $clog2(WORD_W),
  localparam int NSIDE  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [COORD_W-1:0] src_xmin,
  input  logic [COORD_W-1:0] dst_xmin,
  input  logic [COORD_W-1:0] width,
  input  logic [INC_W-1:0]   src_step,
  input  logic [INC_W-1:0]   dst_step,
  input  logic [INC_W-1:0]   src_pitch,
  input  logic [INC_W-1:0]   dst_pitch,
  output logic               busy,
  output logic               done,
  output logic [WORD_W-1:0]  mask_left,
  output logic [WORD_W-1:0]  mask_mid,
  output logic [WORD_W-1:0]  mask_right,
  output logic [OFS_W-1:0]   skew,
  output logic               xfirst,
  output logic               nolast,
  output logic [COORD_W-1:0] words_per_line,
  output logic [COORD_W-1:0] src_span,
  output logic [COORD_W-1:0] dst_span,
  output logic [INC_W-1:0]   src_line_inc,
  output logic [INC_W-1:0]   dst_line_inc
);
  // side 0 = source, side 1 = destination
  calc_state_t state;

  logic [COORD_W-1:0] in_xmin [NSIDE];
  logic [OFS_W-1:0]   c_lo    [NSIDE];
  logic [OFS_W-1:0]   c_hi    [NSIDE];
  logic [COORD_W-1:0] c_span  [NSIDE];

  logic [OFS_W-1:0]   r_lo    [NSIDE];
  logic [OFS_W-1:0]   r_hi    [NSIDE];
  logic [COORD_W-1:0] r_span  [NSIDE];
  logic [INC_W-1:0]   r_step  [NSIDE];
  logic [INC_W-1:0]   r_pitch [NSIDE];
  logic [INC_W-1:0]   n_inc   [NSIDE];

  logic accept;
  assign accept = start && (state == ST_IDLE);
  assign busy   = (state == ST_SPAN);

  always_comb begin
    in_xmin[0] = src_xmin;
    in_xmin[1] = dst_xmin;
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    blit_edge_span #(.COORD_W(COORD_W), .WORD_W(WORD_W)) u_span (
      .xmin   (in_xmin[g]),
      .width  (width),
      .off_lo (c_lo[g]),
      .off_hi (c_hi[g]),
      .span   (c_span[g])
    );
    blit_line_inc #(.COORD_W(COORD_W), .INC_W(INC_W)) u_inc (
      .step  (r_step[g]),
      .pitch (r_pitch[g]),
      .span  (r_span[g]),
      .inc   (n_inc[g])
    );
  end

  // stage 1: capture spans and offsets
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSIDE; i++) begin
        r_lo[i]    <= '0;
        r_hi[i]    <= '0;
        r_span[i]  <= '0;
        r_step[i]  <= '0;
        r_pitch[i] <= '0;
      end
    end else if (accept) begin
      for (int i = 0; i < NSIDE; i++) begin
        r_lo[i]   <= c_lo[i];
        r_hi[i]   <= c_hi[i];
        r_span[i] <= c_span[i];
      end
      r_step[0]  <= src_step;
      r_step[1]  <= dst_step;
      r_pitch[0] <= src_pitch;
      r_pitch[1] <= dst_pitch;
    end
  end

  // stage 2: masks, class, flags
  logic              n_single;
  logic [WORD_W-1:0] n_left, n_right;
  align_class_t      n_cls;
  logic [1:0]        n_flags;

  always_comb begin
    n_single = (r_span[1] == '0);
    n_cls    = {n_single, (r_span[0] == r_span[1]), (r_lo[0] > r_lo[1])};
    n_flags  = read_flags(n_cls);
  end

  blit_mask_gen #(.WORD_W(WORD_W)) u_mask (
    .off_lo  (r_lo[1]),
    .off_hi  (r_hi[1]),
    .single  (n_single),
    .m_left  (n_left),
    .m_right (n_right)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      done           <= 1'b0;
      mask_left      <= '0;
      mask_mid       <= '0;
      mask_right     <= '0;
      skew           <= '0;
      xfirst         <= 1'b0;
      nolast         <= 1'b0;
      words_per_line <= '0;
      src_span       <= '0;
      dst_span       <= '0;
      src_line_inc   <= '0;
      dst_line_inc   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) state <= ST_SPAN;
        ST_SPAN: begin
          state          <= ST_IDLE;
          done           <= 1'b1;
          mask_left      <= n_left;
          mask_mid       <= '1;
          mask_right     <= n_right;
          skew           <= r_lo[1] - r_lo[0];
          xfirst         <= n_flags[1];
          nolast         <= n_flags[0];
          words_per_line <= r_span[1] + COORD_W'(1);
          src_span       <= r_span[0];
          dst_span       <= r_span[1];
          src_line_inc   <= n_inc[0];
          dst_line_inc   <= n_inc[1];
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R2
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done && !busy));
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !busy);
  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(mask_left) && $stable(skew) && $stable(words_per_line)
               && $stable(dst_line_inc)));
  // R8
  single_no_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (done && words_per_line == COORD_W'(1)) |-> !nolast);
  // R4
  wpl_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (words_per_line == dst_span + COORD_W'(1)));
endmodule

// File: tb/tb_blit_align_calc.sv
module tb_blit_align_calc;
  logic clk = 1'b0;
  logic rst;
  logic start;
  logic [15:0] src_xmin, dst_xmin, width, src_step, dst_step, src_pitch, dst_pitch;
  logic busy, done, xfirst, nolast;
  logic [15:0] mask_left, mask_mid, mask_right, words_per_line, src_span, dst_span;
  logic [15:0] src_line_inc, dst_line_inc;
  logic [3:0] skew;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  blit_align_calc dut (
    .clk(clk), .rst(rst), .start(start),
    .src_xmin(src_xmin), .dst_xmin(dst_xmin), .width(width),
    .src_step(src_step), .dst_step(dst_step),
    .src_pitch(src_pitch), .dst_pitch(dst_pitch),
    .busy(busy), .done(done),
    .mask_left(mask_left), .mask_mid(mask_mid), .mask_right(mask_right),
    .skew(skew), .xfirst(xfirst), .nolast(nolast),
    .words_per_line(words_per_line), .src_span(src_span), .dst_span(dst_span),
    .src_line_inc(src_line_inc), .dst_line_inc(dst_line_inc)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_in(input logic [15:0] s, d, w, ss, ds, sp, dp);
    src_xmin = s; dst_xmin = d; width = w;
    src_step = ss; dst_step = ds; src_pitch = sp; dst_pitch = dp;
  endtask

  // check all results against a model computed from the requirements
  task automatic check_results(input logic [15:0] s, d, w, ss, ds, sp, dp);
    logic [15:0] smax, dmax, sspan, dspan, el, er, eml;
    logic [2:0] cls;
    logic [1:0] fl;
    smax  = s + w - 16'd1;
    dmax  = d + w - 16'd1;
    sspan = (smax >> 4) - (s >> 4);
    dspan = (dmax >> 4) - (d >> 4);
    el    = 16'hFFFF >> d[3:0];
    er    = ~(16'h7FFF >> dmax[3:0]);
    eml   = (dspan == 0) ? (el & er) : el;
    cls   = {dspan == 0, sspan == dspan, s[3:0] > d[3:0]};
    case (cls)
      3'd0: fl = 2'b01;
      3'd1: fl = 2'b10;
      3'd3: fl = 2'b11;
      3'd5: fl = 2'b10;
      default: fl = 2'b00;
    endcase
    chk("R4", "src_span", src_span, sspan);
    chk("R4", "dst_span", dst_span, dspan);
    chk("R4", "words_per_line", words_per_line, dspan + 16'd1);
    chk((dspan == 0) ? "R6" : "R5", "mask_left", mask_left, eml);
    chk("R5", "mask_right", mask_right, er);
    chk("R5", "mask_mid", mask_mid, 16'hFFFF);
    chk("R7", "skew", skew, 4'(d[3:0] - s[3:0]));
    chk("R8", "flags", {xfirst, nolast}, fl);
    chk("R9", "src_line_inc", src_line_inc, 16'(sp - ss * sspan));
    chk("R9", "dst_line_inc", dst_line_inc, 16'(dp - ds * dspan));
  endtask

  // full request: start at negedge, check handshake timing and results
  task automatic run_req(input logic [15:0] s, d, w, ss, ds, sp, dp);
    @(negedge clk);
    set_in(s, d, w, ss, ds, sp, dp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", busy, 1'b1);
    chk("R2", "done early", done, 1'b0);
    @(negedge clk);
    chk("R2", "done", done, 1'b1);
    chk("R2", "busy cleared", busy, 1'b0);
    check_results(s, d, w, ss, ds, sp, dp);
    @(negedge clk);
    chk("R2", "done single cycle", done, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "done", done, 1'b0);
    chk("R1", "mask_left", mask_left, 16'h0);
    chk("R1", "words_per_line", words_per_line, 16'h0);
    chk("R1", "flags", {xfirst, nolast}, 2'b00);
    chk("R1", "dst_line_inc", dst_line_inc, 16'h0);
  endtask

  task automatic t_classes();
    run_req(16'd0,  16'd0,  16'd32, 16'd8, 16'd8, 16'd160, 16'd160); // class 2
    run_req(16'd5,  16'd3,  16'd20, 16'd8, 16'd8, 16'd160, 16'd320); // class 3
    run_req(16'd2,  16'd12, 16'd8,  16'd2, 16'd8, 16'd80,  16'd160); // class 0
    run_req(16'd14, 16'd2,  16'd20, 16'd8, 16'd2, 16'd160, 16'd80);  // class 1
    run_req(16'd0,  16'd4,  16'd40, 16'hFFF8, 16'd8, 16'd160, 16'd160);
  endtask

  task automatic t_single_word();
    run_req(16'd10, 16'd2,  16'd5, 16'd8, 16'd8, 16'd160, 16'd160); // class 7
    run_req(16'd13, 16'd2,  16'd5, 16'd8, 16'd8, 16'd160, 16'd160); // class 5
    run_req(16'd0,  16'd2,  16'd5, 16'd8, 16'd8, 16'd160, 16'd160); // class 6
    run_req(16'd1,  16'd35, 16'd1, 16'd8, 16'd8, 16'd40,  16'd40);  // class 6
    run_req(16'd16, 16'd48, 16'd16, 16'd8, 16'd8, 16'd40, 16'd40);  // class 6
  endtask

  // R3: start held into busy cycle with changed inputs
  task automatic t_overlap();
    int dones;
    @(negedge clk);
    set_in(16'd7, 16'd1, 16'd30, 16'd8, 16'd8, 16'd160, 16'd160);
    start = 1'b1;
    @(negedge clk);
    set_in(16'd3, 16'd9, 16'd70, 16'd2, 16'd4, 16'd50, 16'd90);
    @(negedge clk);
    start = 1'b0;
    dones = done ? 1 : 0;
    chk("R3", "first done", done, 1'b1);
    check_results(16'd7, 16'd1, 16'd30, 16'd8, 16'd8, 16'd160, 16'd160);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (done) dones++;
      chk("R3", "no second busy", busy, 1'b0);
    end
    chk("R3", "done pulse count", dones, 1);
    chk("R10", "result held", mask_left, 16'hFFFF >> 1);
    check_results(16'd7, 16'd1, 16'd30, 16'd8, 16'd8, 16'd160, 16'd160);
    // start right after done is accepted
    run_req(16'd3, 16'd9, 16'd70, 16'd2, 16'd4, 16'd50, 16'd90);
  endtask

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    start = 1'b0;
    set_in(16'd0, 16'd0, 16'd1, 16'd0, 16'd0, 16'd0, 16'd0);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_classes();
    t_single_word();
    t_overlap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule